// File: doc/BRIEF.md
# Remote DMA Data Port

This block is the host-side data window into a network controller's local buffer memory. Software first loads a working byte address and a remaining byte count. It then issues a run of single data-port accesses. Each access reads or writes one byte, or one little-endian word, at the working address. After the access the address moves forward by the access size and the count shrinks by the same amount. When the transfer uses up its count, the block sends a one-cycle completion pulse to the interrupt logic.

The address pointer wraps inside the receive ring. When a step lands exactly on the ring's stop page, the pointer returns to the ring's start page. Ring pages are given as page numbers, where a page is 256 bytes. Only two areas of the address space hold storage: a small low area and a packet-memory window. Writes that fall outside both areas never reach the memory port. Reads outside both areas return all ones. A single configuration bit chooses between byte and word transfers. Read data is held in a register and comes with a valid flag.

Top module: `rdma_port`

## Requirements
- R1: After reset the working address, the remaining count, host_rdata, host_rvalid and rdc_pulse are all zero.
- R2: When cfg_word is 1, every access moves 2 bytes. When cfg_word is 0, every access moves 1 byte.
- R3: After each accepted access, the working address becomes the old address plus the access size. If that sum equals ring_stop_pg times 256, the address becomes ring_start_pg times 256 instead.
- R4: If the remaining count is at or below the access size when an access is accepted, the count becomes zero and rdc_pulse is high for exactly the next cycle. Otherwise the count drops by the access size and no pulse is raised.
- R5: A host write issued while the remaining count is zero has no effect: mem_we stays low, the address and count do not change, and no pulse is raised.
- R6: A host read is accepted even when the remaining count is zero. It advances the address, keeps the count at zero and raises rdc_pulse.
- R7: In word mode the memory address has bit 0 cleared and mem_be is 2'b11. Data is little-endian: host bits [7:0] go to the even byte and bits [15:8] go to the odd byte. In byte mode, address bit 0 selects lane 0 (mem_be 2'b01, data bits [7:0]) or lane 1 (mem_be 2'b10, data bits [15:8]).
- R8: An address is valid when it is below 32, or when it is at least 0x4000 and below 0xC000. A write to any other address keeps mem_we low, although the address and count still advance. A read from any other address returns 16'hFFFF in word mode and 16'h00FF in byte mode.
- R9: host_rvalid rises in the cycle after an accepted read, and host_rdata holds the read value in that same cycle. A byte read returns the selected byte in bits [7:0], with bits [15:8] at zero.
- R10: A pulse on ld_addr or ld_cnt replaces the working address or count with the supplied value. Any host access in that same cycle is discarded: no memory write, no read result and no advance.
- R11: When host_wr and host_rd are both high in the same cycle, only the write is considered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 1 | 1 selects word transfers, 0 selects byte transfers |
| ring_start_pg | input | 8 | First page of the receive ring |
| ring_stop_pg | input | 8 | Page one past the end of the receive ring |
| ld_addr | input | 1 | Load strobe for the working address |
| ld_addr_val | input | 16 | New working address |
| ld_cnt | input | 1 | Load strobe for the remaining count |
| ld_cnt_val | input | 16 | New remaining count |
| host_wr | input | 1 | Data-port write strobe |
| host_rd | input | 1 | Data-port read strobe |
| host_wdata | input | 16 | Write data from the host |
| host_rdata | output | 16 | Registered read data |
| host_rvalid | output | 1 | host_rdata holds a new read result |
| mem_addr | output | 16 | Byte address presented to the buffer memory |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read in this cycle |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Write data placed on the byte lanes |
| mem_rdata | input | 16 | Word read back from memory at the even address |
| cur_addr | output | 16 | Working address |
| cur_cnt | output | 16 | Remaining byte count |
| rdc_pulse | output | 1 | Remote transfer complete pulse |

## Verification
The bench runs transfers at both widths and checks the lanes written by reading the same bytes back in the other width. A word write followed by byte reads separates a correct little-endian layout from a swapped one. Separate runs start one step before the ring stop, with both an even and an odd pointer, to tell wrapping on exact equality apart from no wrap at all. Other runs use addresses at 0x1E, 0x20, 0x2000, 0xBFFE and 0xC000 to find each edge of the valid areas. Counts of 3, 5, 1 and 0 separate the three count cases: one below the access size, one equal to it, and one above it. The read-at-zero and write-at-zero cases confirm that the two directions act differently when no bytes are left.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/rdma_window.sv
module rdma_window #(
  parameter int AW        = 16,
  parameter int LOW_LIMIT = 32,
  parameter int WIN_LO    = 16'h4000,
  parameter int WIN_HI    = 16'hC000
) (
  input  logic [AW-1:0] addr,
  output logic          in_window
);
  // Two regions carry storage: a low area and the packet memory.
  logic in_low, in_pkt;
  assign in_low    = addr < AW'(LOW_LIMIT);
  assign in_pkt    = (addr >= AW'(WIN_LO)) && (addr < AW'(WIN_HI));
  assign in_window = in_low || in_pkt;
endmodule

// File: rtl/rdma_lanes.sv
module rdma_lanes #(
  parameter int DW = 16,
  parameter int NB = DW / 8,
  parameter int LB = $clog2(NB)
) (
  input  logic          word_mode,
  input  logic [LB-1:0] lane_sel,
  input  logic          in_window,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] mem_word,
  output logic [NB-1:0] lane_en,
  output logic [DW-1:0] lane_data,
  output logic [DW-1:0] rd_value
);
  // Little-endian lanes: lane g carries byte address offset g.
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_en[g]        = word_mode || (lane_sel == LB'(g));
    assign lane_data[8*g+:8] = word_mode ? wr_data[8*g+:8] : wr_data[7:0];
  end

  logic [7:0] byte_pick;
  assign byte_pick = mem_word[8*lane_sel+:8];

  always_comb begin
    if (!in_window)
      rd_value = word_mode ? {DW{1'b1}} : DW'(8'hFF);
    else
      rd_value = word_mode ? mem_word : DW'(byte_pick);
  end
endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int NB = 2,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_mode,
  input  logic          advance,
  input  logic          ld_addr,
  input  logic [AW-1:0] ld_addr_val,
  input  logic          ld_cnt,
  input  logic [CW-1:0] ld_cnt_val,
  input  logic [PW-1:0] start_pg,
  input  logic [PW-1:0] stop_pg,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          done
);
  localparam int OW = AW - PW;

  // Step the pointer; an exact hit on the ring end folds back to its start.
  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a,
                                               input logic [AW-1:0] step,
                                               input logic [AW-1:0] lo,
                                               input logic [AW-1:0] hi);
    logic [AW-1:0] s;
    s = a + step;
    return (s == hi) ? lo : s;
  endfunction

  // The count saturates at zero once the step reaches or passes it.
  function automatic logic [CW-1:0] cnt_after(input logic [CW-1:0] c,
                                              input logic [CW-1:0] step);
    return (c <= step) ? '0 : c - step;
  endfunction

  logic [AW-1:0] step_a, ring_lo, ring_hi;
  logic [CW-1:0] step_c;
  assign step_a  = word_mode ? AW'(NB) : AW'(1);
  assign step_c  = word_mode ? CW'(NB) : CW'(1);
  assign ring_lo = {start_pg, {OW{1'b0}}};
  assign ring_hi = {stop_pg, {OW{1'b0}}};
  assign done    = advance && (cur_cnt <= step_c);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
    end else begin
      if (ld_addr)      cur_addr <= ld_addr_val;
      else if (advance) cur_addr <= addr_after(cur_addr, step_a, ring_lo, ring_hi);
      if (ld_cnt)       cur_cnt  <= ld_cnt_val;
      else if (advance) cur_cnt  <= cnt_after(cur_cnt, step_c);
    end
  end
endmodule

// File: rtl/rdma_port.sv
module rdma_port #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int PAGE_BITS = 8,
  parameter int LOW_LIMIT = 32,
  parameter int WIN_LO    = 16'h4000,
  parameter int WIN_HI    = 16'hC000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_word,
  input  logic [AW-PAGE_BITS-1:0] ring_start_pg,
  input  logic [AW-PAGE_BITS-1:0] ring_stop_pg,
  input  logic                  ld_addr,
  input  logic [AW-1:0]         ld_addr_val,
  input  logic                  ld_cnt,
  input  logic [CW-1:0]         ld_cnt_val,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [DW-1:0]         host_wdata,
  output logic [DW-1:0]         host_rdata,
  output logic                  host_rvalid,
  output logic [AW-1:0]         mem_addr,
  output logic                  mem_we,
  output logic                  mem_re,
  output logic [DW/8-1:0]       mem_be,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata,
  output logic [AW-1:0]         cur_addr,
  output logic [CW-1:0]         cur_cnt,
  output logic                  rdc_pulse
);
  import rdma_pkg::*;

  localparam int NB = DW / 8;
  localparam int LB = $clog2(NB);
  localparam int PW = AW - PAGE_BITS;

  acc_kind_e     kind;
  logic          any_load, cnt_zero, wr_take, rd_take, step_taken;
  logic          in_window, acc_done;
  logic [AW-1:0] eff_addr;
  logic [DW-1:0] rd_value;

  // Loads win over accesses; a write wins over a read.
  assign any_load = ld_addr || ld_cnt;
  always_comb begin
    if (any_load)     kind = ACC_IDLE;
    else if (host_wr) kind = ACC_WRITE;
    else if (host_rd) kind = ACC_READ;
    else              kind = ACC_IDLE;
  end

  assign cnt_zero   = (cur_cnt == '0);
  assign wr_take    = (kind == ACC_WRITE) && !cnt_zero;
  assign rd_take    = (kind == ACC_READ);
  assign step_taken = wr_take || rd_take;

  assign eff_addr = cfg_word ? {cur_addr[AW-1:LB], {LB{1'b0}}} : cur_addr;

  rdma_window #(
    .AW(AW), .LOW_LIMIT(LOW_LIMIT), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_window (
    .addr      (eff_addr),
    .in_window (in_window)
  );

  rdma_lanes #(.DW(DW), .NB(NB), .LB(LB)) u_lanes (
    .word_mode (cfg_word),
    .lane_sel  (eff_addr[LB-1:0]),
    .in_window (in_window),
    .wr_data   (host_wdata),
    .mem_word  (mem_rdata),
    .lane_en   (mem_be),
    .lane_data (mem_wdata),
    .rd_value  (rd_value)
  );

  rdma_ptr #(.AW(AW), .CW(CW), .NB(NB), .PW(PW)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_mode   (cfg_word),
    .advance     (step_taken),
    .ld_addr     (ld_addr),
    .ld_addr_val (ld_addr_val),
    .ld_cnt      (ld_cnt),
    .ld_cnt_val  (ld_cnt_val),
    .start_pg    (ring_start_pg),
    .stop_pg     (ring_stop_pg),
    .cur_addr    (cur_addr),
    .cur_cnt     (cur_cnt),
    .done        (acc_done)
  );

  assign mem_addr = eff_addr;
  assign mem_we   = wr_take && in_window;
  assign mem_re   = rd_take && in_window;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
      rdc_pulse   <= 1'b0;
    end else begin
      host_rvalid <= rd_take;
      if (rd_take) host_rdata <= rd_value;
      rdc_pulse   <= acc_done;
    end
  end
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk #(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int PW        = 8,
  parameter int NB        = 2,
  parameter int LOW_LIMIT = 32,
  parameter int WIN_LO    = 16'h4000,
  parameter int WIN_HI    = 16'hC000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_word,
  input logic [PW-1:0] ring_start_pg,
  input logic [PW-1:0] ring_stop_pg,
  input logic          ld_addr,
  input logic [AW-1:0] ld_addr_val,
  input logic          ld_cnt,
  input logic          host_wr,
  input logic          host_rd,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [NB-1:0] mem_be,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] cur_cnt,
  input logic          host_rvalid,
  input logic          rdc_pulse,
  input logic          step_taken
);
  localparam int OW = AW - PW;
  logic          no_load;
  logic [CW-1:0] step_c;
  assign no_load = !ld_addr && !ld_cnt;
  assign step_c  = cfg_word ? CW'(NB) : CW'(1);

  p_zero_write_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && no_load && cur_cnt == '0) |-> !mem_we);

  p_zero_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && no_load && cur_cnt == '0) |=> ($stable(cur_addr) && $stable(cur_cnt) && !rdc_pulse));

  p_read_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && no_load && cur_cnt == '0) |=> (rdc_pulse && cur_cnt == '0));

  p_last_step_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_taken && cur_cnt <= step_c) |=> rdc_pulse);

  p_pulse_leaves_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdc_pulse |-> (cur_cnt == '0));

  p_word_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && cfg_word) |-> (mem_addr[0] == 1'b0 && mem_be == '1));

  p_write_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr < AW'(LOW_LIMIT)) || (mem_addr >= AW'(WIN_LO) && mem_addr < AW'(WIN_HI))));

  p_read_valid_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && no_load) |=> host_rvalid);

  p_load_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_addr |=> (cur_addr == $past(ld_addr_val)));

  p_byte_read_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && no_load && !cfg_word &&
     (cur_addr + AW'(1)) == {ring_stop_pg, {OW{1'b0}}})
    |=> (cur_addr == {$past(ring_start_pg), {OW{1'b0}}}));
endmodule

bind rdma_port rdma_port_chk #(
  .AW(AW), .CW(CW), .PW(AW - PAGE_BITS), .NB(DW / 8),
  .LOW_LIMIT(LOW_LIMIT), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_word      (cfg_word),
  .ring_start_pg (ring_start_pg),
  .ring_stop_pg  (ring_stop_pg),
  .ld_addr       (ld_addr),
  .ld_addr_val   (ld_addr_val),
  .ld_cnt        (ld_cnt),
  .host_wr       (host_wr),
  .host_rd       (host_rd),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_be        (mem_be),
  .cur_addr      (cur_addr),
  .cur_cnt       (cur_cnt),
  .host_rvalid   (host_rvalid),
  .rdc_pulse     (rdc_pulse),
  .step_taken    (step_taken)
);

// File: tb/rdma_port_test.sv
`timescale 1ns/1ps
module rdma_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_word = 1'b0;
  logic [7:0]  ring_start_pg = 8'h40, ring_stop_pg = 8'h42;
  logic        ld_addr = 1'b0, ld_cnt = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] ld_addr_val = '0, ld_cnt_val = '0, host_wdata = '0;
  logic [15:0] host_rdata, mem_addr, mem_wdata, mem_rdata, cur_addr, cur_cnt;
  logic        host_rvalid, mem_we, mem_re, rdc_pulse;
  logic [1:0]  mem_be;

  always #10 clk = ~clk;

  rdma_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg),
    .ld_addr(ld_addr), .ld_addr_val(ld_addr_val), .ld_cnt(ld_cnt), .ld_cnt_val(ld_cnt_val),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .rdc_pulse(rdc_pulse)
  );

  // Memory seen by the design, and the bench's own expectation of it.
  logic [7:0] bmem [0:1023];
  logic [7:0] emem [0:1023];
  assign mem_rdata = {bmem[{mem_addr[9:1], 1'b1}], bmem[{mem_addr[9:1], 1'b0}]};
  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_be[0]) bmem[{mem_addr[9:1], 1'b0}] <= mem_wdata[7:0];
      if (mem_be[1]) bmem[{mem_addr[9:1], 1'b1}] <= mem_wdata[15:8];
    end
  end

  int checks = 0, errors = 0;
  int m_addr = 0, m_cnt = 0, m_rdata = 0;
  bit m_rv = 0, m_rdc = 0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ix(input int a);
    return a & 1023;
  endfunction

  // One clock of the reference model, compared against the outputs.
  task automatic cycle();
    int sz, eff, nx;
    bit ld, wr_t, rd_t, ok;
    #2;
    ld   = ld_addr || ld_cnt;
    sz   = cfg_word ? 2 : 1;
    eff  = cfg_word ? (m_addr & 'hFFFE) : m_addr;
    ok   = (eff < 32) || (eff >= 'h4000 && eff < 'hC000);
    wr_t = !ld && host_wr && m_cnt != 0;
    rd_t = !ld && !host_wr && host_rd;
    chk_eq("R5 R8 R10 R11 mem_we", mem_we, wr_t && ok);
    if (wr_t && ok) begin
      chk_eq("R7 mem_addr", mem_addr, eff);
      if (cfg_word) begin
        emem[ix(eff)]     = host_wdata[7:0];
        emem[ix(eff + 1)] = host_wdata[15:8];
      end else begin
        emem[ix(eff)]     = host_wdata[7:0];
      end
    end
    m_rv  = rd_t;
    m_rdc = 0;
    if (rd_t) begin
      if (!ok)           m_rdata = cfg_word ? 'hFFFF : 'h00FF;
      else if (cfg_word) m_rdata = {emem[ix(eff + 1)], emem[ix(eff)]};
      else               m_rdata = {8'h00, emem[ix(eff)]};
    end
    if (wr_t || rd_t) begin
      nx = (m_addr + sz) & 'hFFFF;
      if (nx == (int'(ring_stop_pg) << 8)) nx = int'(ring_start_pg) << 8;
      m_rdc  = (m_cnt <= sz);
      m_cnt  = (m_cnt <= sz) ? 0 : m_cnt - sz;
      m_addr = nx;
    end
    if (ld_addr) m_addr = ld_addr_val;
    if (ld_cnt)  m_cnt  = ld_cnt_val;
    @(posedge clk);
    @(negedge clk);
    chk_eq("R2 R3 address", cur_addr, m_addr);
    chk_eq("R4 count", cur_cnt, m_cnt);
    chk_eq("R4 R6 done pulse", rdc_pulse, m_rdc);
    chk_eq("R9 rvalid", host_rvalid, m_rv);
    if (m_rv) chk_eq("R7 R8 R9 rdata", host_rdata, m_rdata);
    host_wr = 0; host_rd = 0; ld_addr = 0; ld_cnt = 0;
  endtask

  task automatic do_ld(input int a, input int c);
    ld_addr = 1; ld_addr_val = 16'(a); ld_cnt = 1; ld_cnt_val = 16'(c);
    cycle();
  endtask
  task automatic do_wr(input int d);
    host_wr = 1; host_wdata = 16'(d);
    cycle();
  endtask
  task automatic do_rd();
    host_rd = 1;
    cycle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stimulus
    for (int i = 0; i < 1024; i++) begin bmem[i] = 8'h00; emem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_eq("R1 cur_addr", cur_addr, 0);
    chk_eq("R1 cur_cnt", cur_cnt, 0);
    chk_eq("R1 rvalid", host_rvalid, 0);
    chk_eq("R1 rdc_pulse", rdc_pulse, 0);
    chk_eq("R1 rdata", host_rdata, 0);
    rst_n = 1;

    // R2 R4 R5: byte writes, count runs out, then an ignored write
    cfg_word = 0;
    do_ld('h4000, 3);
    do_wr('h00A1); do_wr('h00A2); do_wr('h00A3);
    do_wr('h00EE);
    do_ld('h4000, 3);
    do_rd(); do_rd(); do_rd();

    // R7: word writes at an odd pointer, read back as words and bytes
    cfg_word = 1;
    do_ld('h4101, 5);
    do_wr('h1234); do_wr('h5678); do_wr('h9ABC);
    do_ld('h4100, 4);
    do_rd(); do_rd();
    cfg_word = 0;
    do_ld('h4100, 6);
    do_rd(); do_rd(); do_rd(); do_rd();

    // R3: wrap at the ring stop, word and byte
    cfg_word = 1;
    do_ld('h41FE, 10);
    do_wr('hCAFE); do_wr('hBEEF);
    cfg_word = 0;
    do_ld('h41FF, 10);
    do_wr('h0077); do_rd();
    ring_start_pg = 8'h46; ring_stop_pg = 8'h48;
    do_ld('h47FF, 2);
    do_rd();
    ring_start_pg = 8'h40; ring_stop_pg = 8'h42;

    // R8: window edges
    cfg_word = 1;
    do_ld('h001E, 8);
    do_wr('h4455); do_wr('h6677);
    do_ld('h001E, 8);
    do_rd(); do_rd();
    do_ld('hBFFE, 4);
    do_wr('h1122); do_wr('h3344);
    do_ld('hBFFE, 4);
    do_rd(); do_rd();
    cfg_word = 0;
    do_ld('h2000, 2);
    do_wr('h0055); do_rd();
    do_ld('h0020, 2);
    do_rd();

    // R6: reads with count zero still move
    do_ld('h4000, 0);
    do_rd(); do_rd();
    do_wr('h0011);

    // R10 R11: load beats access; write beats read
    do_ld('h4010, 4);
    ld_addr = 1; ld_addr_val = 16'h4020; host_wr = 1; host_wdata = 16'h00DD;
    cycle();
    ld_cnt = 1; ld_cnt_val = 16'd9; host_rd = 1;
    cycle();
    host_wr = 1; host_rd = 1; host_wdata = 16'h0042;
    cycle();
    do_ld('h4020, 1);
    do_rd();

    // Mixed pattern sweep
    for (int k = 0; k < 40; k++) begin
      cfg_word = k[0];
      if (k % 7 == 0) do_ld('h41F0 + k, (k % 5) + 1);
      else if (k % 3 == 0) do_rd();
      else do_wr(k * 'h0301);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule